// File: doc/BRIEF.md
# Raw NAND Flash Bus Command Front End

This block is the device side of a raw NAND flash bus. Each cycle with `we` high and chip enable asserted is one bus write. With the command-latch pin high the byte is an opcode. With the address-latch pin high it is one address cycle. With neither high it is a data word for page programming. Each cycle with `re` high and chip enable asserted is one bus read. `dout` always shows the word that the next read returns, and the read moves the pointer on.

The block decodes opcodes and counts address cycles. It assembles the column and row, and decides the cycle in which an operation starts. That cycle depends on the geometry parameters: small page, large page up to 1 Gbit, or large page of 2 Gbit and above. Read data comes from an internal byte buffer. The cell array lies outside the block. A page read raises a one-cycle `load_req` with the row number, and the array then writes bytes into the buffer through the fill port.

On a 16-bit bus the column becomes a byte address. Identification and status bytes appear zero-extended on the wider bus.

Top module: `nandif_front`

## Requirements
- R1: After reset, with chip enable asserted and no command issued, `dout` is 0 and `load_req` is 0. A status read issued next returns 0xE0 when `wp_n` is high.
- R2: Opcode 0x90 followed by exactly one address cycle starts identification. Successive reads return the manufacturer code, then the device code, then the filler code. The fourth read returns 0x15 for an 8-bit large-page part, 0x55 for a 16-bit large-page part and 0xC0 for a small-page part. Every later read returns 0.
- R3: On a 16-bit bus, identification and status bytes appear in bits 7:0 and bits 15:8 are zero.
- R4: After opcode 0x70, every read returns the status and moves no pointer. Bit 7 of the status is `wp_n`. After opcode 0xFF, bits 6 and 5 are 1 and bits 4:0 are 0.
- R5: After opcode 0x00, `load_req` pulses for one cycle following a fixed address cycle: the 3rd on small-page parts, the 4th on large-page parts up to 1 Gbit, and the 5th on larger parts. `load_row` then carries the address cycles that follow the column, first cycle in the low byte.
- R6: On large-page parts, opcode 0x30, 0x31 or 0x3F arriving while the pending opcode is 0x00 is absorbed, and the read output is unchanged.
- R7: On a 16-bit bus, the column given in the first two address cycles is doubled into a byte address once the second cycle arrives.
- R8: In a page read, each read returns the buffer bytes at pointer p and p+1 (16-bit bus), with byte p in bits 7:0. The pointer then advances by the bus width in bytes.
- R9: `dout` is 0 while `ce_n` is high, and a read strobe in that state moves nothing. `dout` is also 0 once the pointer has reached the end of the buffer.
- R10: Opcode 0x05, then two column cycles, then opcode 0xE0 moves the read pointer to the new column without a new load request.
- R11: After opcode 0x80 and its full address, data words are written into the buffer from the column onward, low byte at the lower address. A following page read returns them.
- R12: Opcode 0x34 ends a cache read, and later reads return 0.
- R13: Any newly latched opcode ends the repeating status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| wp_n | input | 1 | Write protect, active low |
| we | input | 1 | Bus write strobe for this cycle |
| re | input | 1 | Bus read strobe for this cycle |
| din | input | BUS_W | Write data / opcode / address byte (bits 7:0) |
| dout | output | BUS_W | Word returned by the next read |
| load_req | output | 1 | One-cycle request to load a page into the buffer |
| load_row | output | 24 | Row number for the load request |
| fill_we | input | 1 | Buffer fill strobe from the array side |
| fill_addr | input | $clog2(BUF_BYTES) | Buffer byte index to fill |
| fill_data | input | 8 | Fill byte |

## Verification
The hardest state to reach is a page read on a 16-bit, 2 Gbit geometry where a cache-read confirm has been absorbed and the pointer is then moved by a random data-out. It takes a precise sequence of opcode, five address cycles, confirm, second opcode pair and two more address cycles. The bench fills the buffer with a known pattern and drives these sequences through bus tasks. It then reads back words whose byte order and position show at once whether the column was doubled and whether the confirm was absorbed. A second instance with 8-bit small-page geometry runs beside the first on the same stimulus, to show the earlier trigger cycle and the other fourth identification byte.

// File: rtl/nandif_pkg.sv
package nandif_pkg;
  localparam logic [7:0] OP_RD_SETUP   = 8'h00;
  localparam logic [7:0] OP_RD_CONFIRM = 8'h30;
  localparam logic [7:0] OP_CACHE_GO   = 8'h31;
  localparam logic [7:0] OP_CACHE_END  = 8'h3F;
  localparam logic [7:0] OP_CACHE_QUIT = 8'h34;
  localparam logic [7:0] OP_RND_SETUP  = 8'h05;
  localparam logic [7:0] OP_RND_GO     = 8'hE0;
  localparam logic [7:0] OP_IDENT      = 8'h90;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_RESET      = 8'hFF;
  localparam logic [7:0] OP_PROG_SETUP = 8'h80;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_ARRAY = 2'd1,
    OUT_STAT  = 2'd2,
    OUT_IDENT = 2'd3
  } out_mode_e;
endpackage

// File: rtl/nandif_seq.sv
module nandif_seq
  import nandif_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int LARGE_PAGE = 1,
  parameter int WIDE_ARRAY = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        cle,
  input  logic        ale,
  input  logic        we,
  input  logic [7:0]  din_lo,
  output logic        ev_cmd,
  output logic        ev_ident,
  output logic        ev_stat,
  output logic        ev_rst,
  output logic        ev_exit,
  output logic        ev_rnd,
  output logic        ev_rd,
  output logic        ev_pg,
  output logic        ev_data,
  output logic [15:0] col_o,
  output logic [23:0] row_o
);
  localparam int CW       = (LARGE_PAGE != 0) ? 16 : 8;
  localparam int TRIG     = (LARGE_PAGE != 0) ? ((WIDE_ARRAY != 0) ? 5 : 4) : 3;
  localparam int MAX_ACYC = 5;

  logic [7:0]  cmd_q, cmd_d;
  logic [2:0]  acyc_q, acyc_d;
  logic [39:0] addr_q, addr_d;
  logic        wr, absorb;

  always_comb begin
    cmd_d    = cmd_q;
    acyc_d   = acyc_q;
    addr_d   = addr_q;
    ev_cmd   = 1'b0;
    ev_ident = 1'b0;
    ev_stat  = 1'b0;
    ev_rst   = 1'b0;
    ev_exit  = 1'b0;
    ev_rnd   = 1'b0;
    ev_rd    = 1'b0;
    ev_pg    = 1'b0;
    ev_data  = 1'b0;
    wr       = we && !ce_n;
    absorb   = (LARGE_PAGE != 0) && (cmd_q == OP_RD_SETUP) &&
               ((din_lo == OP_RD_CONFIRM) || (din_lo == OP_CACHE_GO) ||
                (din_lo == OP_CACHE_END));
    if (wr && cle) begin
      if (!absorb) begin
        cmd_d   = din_lo;
        acyc_d  = 3'd0;
        ev_cmd  = 1'b1;
        ev_stat = (din_lo == OP_STATUS);
        ev_rst  = (din_lo == OP_RESET);
        ev_exit = (din_lo == OP_CACHE_QUIT);
        ev_rnd  = (din_lo == OP_RND_GO);
      end
    end else if (wr && ale) begin
      if (acyc_q < 3'(MAX_ACYC)) begin
        addr_d[{acyc_q, 3'b000} +: 8] = din_lo;
        acyc_d = acyc_q + 3'd1;
        if ((BUS_W == 16) && (acyc_d == 3'd2))
          addr_d[CW-1:0] = {addr_d[CW-2:0], 1'b0};
        ev_ident = (acyc_d == 3'd1) && (cmd_q == OP_IDENT);
        ev_rd    = (acyc_d == 3'(TRIG)) && (cmd_q == OP_RD_SETUP);
        ev_pg    = (acyc_d == 3'(TRIG)) && (cmd_q == OP_PROG_SETUP);
      end
    end else if (wr) begin
      ev_data = (cmd_q == OP_PROG_SETUP);
    end
  end

  assign col_o = 16'(addr_d[CW-1:0]);
  assign row_o = addr_d[CW +: 24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= OP_RESET;
      acyc_q <= 3'd0;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      acyc_q <= acyc_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/nandif_pbuf.sv
module nandif_pbuf #(
  parameter int BUS_W     = 16,
  parameter int BUF_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_start,
  input  logic                         rnd_start,
  input  logic [15:0]                  col,
  input  logic                         pg_start,
  input  logic                         data_we,
  input  logic [BUS_W-1:0]             wdata,
  input  logic                         rd_adv,
  input  logic                         fill_we,
  input  logic [$clog2(BUF_BYTES)-1:0] fill_addr,
  input  logic [7:0]                   fill_data,
  output logic [BUS_W-1:0]             rdata,
  output logic                         rd_avail
);
  localparam int NB = BUS_W / 8;
  localparam int AW = $clog2(BUF_BYTES);
  localparam int PW = AW + 1;

  logic [7:0]    mem_q [BUF_BYTES];
  logic [PW-1:0] rptr_q, rptr_d, wptr_q, wptr_d, col_ptr;
  logic          wr_ok;

  assign col_ptr  = (col < 16'(BUF_BYTES)) ? col[PW-1:0] : PW'(BUF_BYTES);
  assign rd_avail = (rptr_q <= PW'(BUF_BYTES - NB));
  assign wr_ok    = (wptr_q <= PW'(BUF_BYTES - NB));

  always_comb begin
    rptr_d = rptr_q;
    if (rd_start || rnd_start)   rptr_d = col_ptr;
    else if (rd_adv && rd_avail) rptr_d = rptr_q + PW'(NB);
    wptr_d = wptr_q;
    if (pg_start)                wptr_d = col_ptr;
    else if (data_we && wr_ok)   wptr_d = wptr_q + PW'(NB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NB; k++) begin
      if (data_we && wr_ok)
        mem_q[wptr_q[AW-1:0] + AW'(k)] <= wdata[8*k +: 8];
    end
    if (fill_we)
      mem_q[fill_addr] <= fill_data;
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign rdata[8*k +: 8] = mem_q[rptr_q[AW-1:0] + AW'(k)];
  end
endmodule

// File: rtl/nandif_front.sv
module nandif_front
  import nandif_pkg::*;
#(
  parameter int         BUS_W      = 16,
  parameter int         LARGE_PAGE = 1,
  parameter int         WIDE_ARRAY = 1,
  parameter int         BUF_BYTES  = 64,
  parameter logic [7:0] MFR_CODE   = 8'h2C,
  parameter logic [7:0] DEV_CODE   = 8'hCA,
  parameter logic [7:0] FILL_CODE  = 8'hA5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ce_n,
  input  logic                         cle,
  input  logic                         ale,
  input  logic                         wp_n,
  input  logic                         we,
  input  logic                         re,
  input  logic [BUS_W-1:0]             din,
  output logic [BUS_W-1:0]             dout,
  output logic                         load_req,
  output logic [23:0]                  load_row,
  input  logic                         fill_we,
  input  logic [$clog2(BUF_BYTES)-1:0] fill_addr,
  input  logic [7:0]                   fill_data
);
  localparam logic [7:0] ID_LAST = (LARGE_PAGE != 0) ? ((BUS_W == 16) ? 8'h55 : 8'h15) : 8'hC0;
  localparam logic [7:0] ST_RESET = 8'hE0;
  localparam logic [6:0] ST_READY = 7'h60;

  logic ev_cmd, ev_ident, ev_stat, ev_rst, ev_exit, ev_rnd, ev_rd, ev_pg, ev_data;
  logic [15:0] col;
  logic [23:0] row;
  logic [BUS_W-1:0] rdata;
  logic rd_avail, rd_fire;

  out_mode_e   mode_q, mode_d;
  logic [2:0]  idx_q, idx_d;
  logic [7:0]  status_q, status_d, id_byte;
  logic        load_req_q;
  logic [23:0] load_row_q, load_row_d;

  nandif_seq #(.BUS_W(BUS_W), .LARGE_PAGE(LARGE_PAGE), .WIDE_ARRAY(WIDE_ARRAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we),
    .din_lo(din[7:0]), .ev_cmd(ev_cmd), .ev_ident(ev_ident), .ev_stat(ev_stat),
    .ev_rst(ev_rst), .ev_exit(ev_exit), .ev_rnd(ev_rnd), .ev_rd(ev_rd),
    .ev_pg(ev_pg), .ev_data(ev_data), .col_o(col), .row_o(row)
  );

  assign rd_fire = re && !ce_n && !we;

  nandif_pbuf #(.BUS_W(BUS_W), .BUF_BYTES(BUF_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .rd_start(ev_rd), .rnd_start(ev_rnd), .col(col),
    .pg_start(ev_pg), .data_we(ev_data), .wdata(din),
    .rd_adv(rd_fire && (mode_q == OUT_ARRAY)),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .rdata(rdata), .rd_avail(rd_avail)
  );

  always_comb begin
    mode_d = mode_q;
    idx_d  = idx_q;
    if (ev_cmd)            mode_d = OUT_IDLE;
    if (ev_stat)           mode_d = OUT_STAT;
    if (ev_rnd || ev_rd)   mode_d = OUT_ARRAY;
    if (ev_ident) begin
      mode_d = OUT_IDENT;
      idx_d  = 3'd0;
    end else if (rd_fire && (mode_q == OUT_IDENT) && (idx_q < 3'd4)) begin
      idx_d = idx_q + 3'd1;
    end
    status_d = {wp_n, status_q[6:0]};
    if (ev_rst) status_d = {wp_n, ST_READY};
    load_row_d = ev_rd ? row : load_row_q;
  end

  always_comb begin
    case (idx_q)
      3'd0:    id_byte = MFR_CODE;
      3'd1:    id_byte = DEV_CODE;
      3'd2:    id_byte = FILL_CODE;
      3'd3:    id_byte = ID_LAST;
      default: id_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= OUT_IDLE;
      idx_q      <= 3'd4;
      status_q   <= ST_RESET;
      load_req_q <= 1'b0;
      load_row_q <= '0;
    end else begin
      mode_q     <= mode_d;
      idx_q      <= idx_d;
      status_q   <= status_d;
      load_req_q <= ev_rd;
      load_row_q <= load_row_d;
    end
  end

  always_comb begin
    dout = '0;
    if (!ce_n) begin
      case (mode_q)
        OUT_STAT:  dout = BUS_W'(status_q);
        OUT_IDENT: dout = BUS_W'(id_byte);
        OUT_ARRAY: dout = rd_avail ? rdata : '0;
        default:   dout = '0;
      endcase
    end
  end

  assign load_req = load_req_q;
  assign load_row = load_row_q;
endmodule

// File: rtl/nandif_front_chk.sv
module nandif_front_chk
  import nandif_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             we,
  input logic             re,
  input logic             wp_n,
  input logic [BUS_W-1:0] dout,
  input logic             load_req,
  input logic [1:0]       mode,
  input logic [7:0]       status,
  input logic             ev_rst,
  input logic             ev_exit
);
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'(OUT_STAT)) && re && !we && !ce_n && (wp_n == status[7])
    |=> ce_n || (dout == $past(dout))); // R4

  AST_RESET_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst |=> (status[6:5] == 2'b11) && (status[4:0] == 5'd0)); // R4

  AST_NARROW_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'(OUT_STAT)) || (mode == 2'(OUT_IDENT))) |-> (BUS_W'(dout >> 8) == '0)); // R3

  AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exit |=> (mode == 2'(OUT_IDLE))); // R12

  AST_CE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (dout == '0)); // R9
endmodule

bind nandif_front nandif_front_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we(we), .re(re), .wp_n(wp_n),
  .dout(dout), .load_req(load_req), .mode(mode_q), .status(status_q),
  .ev_rst(ev_rst), .ev_exit(ev_exit)
);

// File: tb/nandif_front_tb.sv
module nandif_front_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, ce_n, cle, ale, wp_n, we, re;
  logic [15:0] din;
  logic        fill_we;
  logic [5:0]  fill_addr;
  logic [7:0]  fill_data;
  logic [15:0] dout16;
  logic [7:0]  dout8;
  logic        lr16, lr8;
  logic [23:0] row16, row8;
  int checks, failures;
  logic [15:0] w16;
  logic [7:0]  w8;

  // {confirm opcode, word column, expected word}
  localparam logic [31:0] VEC [4] = '{
    {8'h30, 8'd0,  16'h5B5A},
    {8'h31, 8'd3,  16'h5D5C},
    {8'h3F, 8'd10, 16'h4F4E},
    {8'h30, 8'd31, 16'h6564}
  };

  nandif_front u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .we(we), .re(re), .din(din), .dout(dout16), .load_req(lr16), .load_row(row16),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  nandif_front #(.BUS_W(8), .LARGE_PAGE(0), .WIDE_ARRAY(0)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .we(we), .re(re), .din(din[7:0]), .dout(dout8), .load_req(lr8), .load_row(row8),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cle = 1'b1; we = 1'b1; din = {8'h00, b};
    @(negedge clk); cle = 1'b0; we = 1'b0;
  endtask

  task automatic adr(input logic [7:0] b);
    @(negedge clk); ale = 1'b1; we = 1'b1; din = {8'h00, b};
    @(negedge clk); ale = 1'b0; we = 1'b0;
  endtask

  task automatic dat(input logic [15:0] w);
    @(negedge clk); we = 1'b1; din = w;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd;
    @(negedge clk); w16 = dout16; w8 = dout8; re = 1'b1;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic page_read(input logic [7:0] c, input logic [7:0] conf);
    cmd(8'h00); adr(c); adr(8'h00); adr(8'h11); adr(8'h22); adr(8'h33); cmd(conf);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we = 1'b0; re = 1'b0;
    wp_n = 1'b1; din = '0; fill_we = 1'b0; fill_addr = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 load_req after reset", 32'(lr16), 32'd0);
    ce_n = 1'b0;
    @(negedge clk);
    chk("R1 idle dout", 32'(dout16), 32'd0);
    cmd(8'h70); rd;
    chk("R1 status after reset", 32'(w16), 32'h00E0);
    chk("R1 status after reset x8", 32'(w8), 32'hE0);

    for (int i = 0; i < 64; i++) begin
      @(negedge clk); fill_we = 1'b1; fill_addr = 6'(i); fill_data = 8'(i) ^ 8'h5A;
    end
    @(negedge clk); fill_we = 1'b0;

    // R5 R6 R7 R8: table of page reads with different confirms and columns
    for (int i = 0; i < 4; i++) begin
      cmd(8'h00); adr(VEC[i][23:16]); adr(8'h00); adr(8'h11);
      chk("R5 x8 small-page trigger on 3rd cycle", 32'(lr8), 32'd1);
      chk("R5 x8 row low bytes", 32'(row8[15:0]), 32'h1100);
      adr(8'h22);
      chk("R5 no trigger on 4th cycle", 32'(lr16), 32'd0);
      adr(8'h33);
      chk("R5 trigger on 5th cycle", 32'(lr16), 32'd1);
      chk("R5 load row", 32'(row16), 32'h332211);
      @(negedge clk);
      chk("R5 single pulse", 32'(lr16), 32'd0);
      cmd(VEC[i][31:24]);
      rd;
      chk("R6 R7 R8 table read", 32'(w16), 32'(VEC[i][15:0]));
    end

    // R8: pointer advances by two bytes, little endian
    page_read(8'd0, 8'h30);
    rd; chk("R8 word0", 32'(w16), 32'h5B5A);
    rd; chk("R8 word1", 32'(w16), 32'h5958);
    rd; chk("R8 word2", 32'(w16), 32'h5F5E);

    // R9: chip enable high silences output and blocks advance
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); chk("R9 ce high dout", 32'(dout16), 32'd0);
    rd; chk("R9 ce high read", 32'(w16), 32'd0);
    @(negedge clk); ce_n = 1'b0;
    rd; chk("R9 no advance while ce high", 32'(w16), 32'h5D5C);

    // R9: end of buffer
    page_read(8'd31, 8'h30);
    rd; chk("R9 last word", 32'(w16), 32'h6564);
    rd; chk("R9 exhausted", 32'(w16), 32'd0);

    // R10: random data out
    cmd(8'h05); adr(8'd10); adr(8'd0); cmd(8'hE0);
    chk("R10 no load request", 32'(lr16), 32'd0);
    rd; chk("R10 moved pointer", 32'(w16), 32'h4F4E);
    rd; chk("R10 next word", 32'(w16), 32'h4D4C);

    // R12: cache exit
    cmd(8'h34); rd;
    chk("R12 after cache exit", 32'(w16), 32'd0);

    // R11: program data entry into buffer, read back
    cmd(8'h80); adr(8'd2); adr(8'd0); adr(8'h01); adr(8'h02); adr(8'h03);
    dat(16'hBEEF); dat(16'h1234); cmd(8'h10);
    page_read(8'd2, 8'h30);
    rd; chk("R11 program word0", 32'(w16), 32'hBEEF);
    rd; chk("R11 program word1", 32'(w16), 32'h1234);

    // R2 R3: identification
    cmd(8'h90); adr(8'h00);
    rd; chk("R2 R3 manufacturer", 32'(w16), 32'h002C); chk("R2 x8 manufacturer", 32'(w8), 32'h2C);
    rd; chk("R2 R3 device", 32'(w16), 32'h00CA);       chk("R2 x8 device", 32'(w8), 32'hCA);
    rd; chk("R2 filler", 32'(w16), 32'h00A5);
    rd; chk("R2 R3 fourth x16 large", 32'(w16), 32'h0055); chk("R2 fourth small page", 32'(w8), 32'hC0);
    rd; chk("R2 past end", 32'(w16), 32'd0);

    // R4 R13: status stickiness and reset command
    cmd(8'hFF); cmd(8'h70);
    for (int k = 0; k < 3; k++) begin
      rd; chk("R4 R3 sticky status", 32'(w16), 32'h00E0);
    end
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk);
    rd; chk("R4 protect bit follows wp_n", 32'(w16), 32'h0060);
    @(negedge clk); wp_n = 1'b1;
    cmd(8'h90); adr(8'h00);
    rd; chk("R13 new command ends status", 32'(w16), 32'h002C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule